// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns bytes from a 64-entry transmit buffer into asynchronous serial characters on `tx_o`. Each character is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop interval. Every bit lasts 16 pulses of the `tick_i` enable, which a baud divisor outside this block supplies at sixteen times the bit rate. The character format comes from a six-bit line-control input and is captured when each character starts.

Automatic clear-to-send gating is on only when `flow_auto_i` and `cts_sel_i` are both high. While it is on and `cts_ni` is high, meaning the remote receiver is busy, no new start bit is sent. A character that has already started always finishes. Two flags report whether the buffer is empty and whether the whole transmitter is idle.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset `tx_o` is 1 and both `thr_empty_o` and `tx_empty_o` are 1.
- R2: A character starts with `tx_o` low for 16 ticks. The data bits follow, least significant bit first, and each bit lasts 16 ticks. `tx_o` changes only in the clock cycle after a cycle in which `tick_i` is high.
- R3: `lcr_i[1:0]` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the word length are not sent.
- R4: `lcr_i[5:3]` selects the parity. xx0 sends no parity bit. 001 sends odd parity and 011 sends even parity, computed over the sent data bits only. 101 sends a constant 1 and 111 sends a constant 0.
- R5: The stop interval is high. It lasts 16 ticks when `lcr_i[2]` is 0. When `lcr_i[2]` is 1 it lasts 24 ticks for 5-bit words and 32 ticks otherwise. When the buffer holds another byte and sending is allowed, the next start bit follows the stop interval with no gap.
- R6: The buffer holds 64 bytes and sends them in write order. A write while 64 bytes are held is discarded.
- R7: When `flow_auto_i` and `cts_sel_i` are both 1 and `cts_ni` is 1, no new character starts. A character already in progress completes.
- R8: When either `flow_auto_i` or `cts_sel_i` is 0, `cts_ni` has no effect.
- R9: `thr_empty_o` is 1 exactly when the buffer is empty. `tx_empty_o` is 1 when the buffer is empty and no character is in progress, through the end of the stop interval.
- R10: The format in force for a character is the `lcr_i` value at its start. Changes to `lcr_i` during the character do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en_i | input | 1 | Writes `wr_data_i` into the buffer |
| wr_data_i | input | 8 | Byte to send |
| lcr_i | input | 6 | Format: [1:0] word length, [2] long stop, [5:3] parity |
| flow_auto_i | input | 1 | Automatic flow control select (one of two enables) |
| cts_sel_i | input | 1 | Clear-to-send gating select (the other enable) |
| cts_ni | input | 1 | Remote busy when 1 |
| tx_o | output | 1 | Serial output, idles high |
| thr_empty_o | output | 1 | Buffer empty |
| tx_empty_o | output | 1 | Buffer empty and shifter idle |

## Verification
The assertions check properties that hold on every cycle:
- `tx_o` moves only after a tick.
- The line is high whenever the shifter is idle.
- The buffer is never popped when empty, and a write to a full buffer leaves its occupancy unchanged.
- An idle transmitter stays idle during a cycle in which gating was active.
- The captured format is stable during a character.

Only the bench scenarios can show the rest:
- bit order and parity values for each word length and parity mode;
- exact stop lengths, measured from start edge to start edge in back-to-back pairs;
- completion of a character when gating rises during it;
- the 64-byte limit with the 65th write dropped;
- the timing of the two empty flags at the ports.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned TICKS_PER_BIT = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;       // 0..3 -> 5..8 bits
    logic       stop_long;
    logic       par_en;
    logic       par_even;
    logic       par_force;
  } line_fmt_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          full, do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> $stable(count_q)); // R6
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  line_fmt_t     fmt_i,
  input  logic          avail_i,
  input  logic          block_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          tx_o,
  output logic          busy_o
);
  localparam int unsigned CNTW  = 5;
  localparam int unsigned IDXW  = $clog2(DW);
  localparam logic [CNTW-1:0] BIT_LAST = CNTW'(TICKS_PER_BIT - 1);

  tx_state_e       state_q;
  line_fmt_t       fmt_q;
  logic [DW-1:0]   shreg_q;
  logic            par_q;
  logic [CNTW-1:0] cnt_q;
  logic [IDXW-1:0] idx_q;
  logic [CNTW-1:0] stop_last;
  logic [IDXW-1:0] idx_last;
  logic [DW-1:0]   mask;
  logic            par_new;

  assign stop_last = !fmt_q.stop_long ? BIT_LAST :
                     (fmt_q.wlen == 2'd0) ? CNTW'(TICKS_PER_BIT * 3 / 2 - 1)
                                          : CNTW'(TICKS_PER_BIT * 2 - 1);
  assign idx_last  = IDXW'(fmt_q.wlen) + IDXW'(4);
  assign mask      = {DW{1'b1}} >> (3'd3 - {1'b0, fmt_i.wlen});
  assign par_new   = fmt_i.par_force ? !fmt_i.par_even :
                     fmt_i.par_even  ? ^(data_i & mask) : ~^(data_i & mask);

  assign pop_o  = tick_i && avail_i && !block_i &&
                  (state_q == ST_IDLE || (state_q == ST_STOP && cnt_q == stop_last));
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = shreg_q[0];
      ST_PAR:   tx_o = par_q;
      default:  tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fmt_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (pop_o) begin
      state_q <= ST_START;
      fmt_q   <= fmt_i;
      shreg_q <= data_i;
      par_q   <= par_new;
      cnt_q   <= '0;
    end else if (tick_i) begin
      case (state_q)
        ST_START: begin
          cnt_q <= (cnt_q == BIT_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == BIT_LAST) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
        end
        ST_DATA: begin
          if (cnt_q == BIT_LAST) begin
            cnt_q   <= '0;
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 1'b1;
            if (idx_q == idx_last) state_q <= fmt_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          cnt_q <= (cnt_q == BIT_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == BIT_LAST) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (cnt_q == stop_last) state_q <= ST_IDLE;
          else                    cnt_q <= cnt_q + 1'b1;
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  AST_TX_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_o != $past(tx_o)) |-> $past(tick_i)); // R2
  AST_FMT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(pop_o)) |-> $stable(fmt_q)); // R10
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
  import uart_tx_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [5:0]    lcr_i,
  input  logic          flow_auto_i,
  input  logic          cts_sel_i,
  input  logic          cts_ni,
  output logic          tx_o,
  output logic          thr_empty_o,
  output logic          tx_empty_o
);
  line_fmt_t     fmt;
  logic [DW-1:0] head;
  logic          empty, pop, busy, block;

  assign fmt.wlen      = lcr_i[1:0];
  assign fmt.stop_long = lcr_i[2];
  assign fmt.par_en    = lcr_i[3];
  assign fmt.par_even  = lcr_i[4];
  assign fmt.par_force = lcr_i[5];

  assign block = flow_auto_i && cts_sel_i && cts_ni;

  uart_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (empty)
  );

  uart_tx_shift #(.DW(DW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .fmt_i   (fmt),
    .avail_i (!empty),
    .block_i (block),
    .data_i  (head),
    .pop_o   (pop),
    .tx_o    (tx_o),
    .busy_o  (busy)
  );

  assign thr_empty_o = empty;
  assign tx_empty_o  = empty && !busy;

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> tx_o); // R5
  AST_CTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy) && $past(block)) |-> !busy); // R7
endmodule

// File: tb/uart_tx_cts_test.sv
module uart_tx_cts_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int BITC       = 16 * DIV;

  typedef struct {
    logic [7:0] d;
    int         wl;
    logic [2:0] pm;
    logic       sl;
    bit         gap;
  } item_t;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [5:0] lcr = 6'b000011;
  logic flow_auto = 0, cts_sel = 0, cts_n = 0;
  logic tx, thr_empty, tx_empty;

  int checks = 0, fails = 0, n_start = 0, n_done = 0;
  longint cyc = 0;
  bit finished = 0;
  item_t q[$];

  uart_tx_cts uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .lcr_i(lcr), .flow_auto_i(flow_auto),
    .cts_sel_i(cts_sel), .cts_ni(cts_n), .tx_o(tx),
    .thr_empty_o(thr_empty), .tx_empty_o(tx_empty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == DIV - 1);
      c = (c == DIV - 1) ? 0 : c + 1;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int stop_ticks(item_t it);
    return it.sl ? ((it.wl == 5) ? 24 : 32) : 16;
  endfunction

  function automatic int frame_ticks(item_t it);
    return 16 * (1 + it.wl + (it.pm[0] ? 1 : 0)) + stop_ticks(it);
  endfunction

  function automatic logic exp_par(item_t it);
    logic x = 0;
    for (int i = 0; i < it.wl; i++) x ^= it.d[i];
    case (it.pm)
      3'b001:  return ~x;
      3'b011:  return x;
      3'b101:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_fmt(int wl, logic [2:0] pm, logic sl);
    @(negedge clk);
    lcr = {pm, sl, 2'(wl - 5)};
  endtask

  task automatic write_byte(logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(logic [7:0] d, bit gap);
    item_t it;
    it.d = d; it.wl = int'(lcr[1:0]) + 5; it.pm = lcr[5:3]; it.sl = lcr[2]; it.gap = gap;
    q.push_back(it);
    write_byte(d);
  endtask

  task automatic wait_done(int target);
    while (n_done < target) @(negedge clk);
  endtask

  task automatic wait_start(int target);
    while (n_start < target) @(negedge clk);
  endtask

  // Monitor: decodes frames on tx and compares with the scoreboard queue
  initial begin : monitor
    logic prev = 1;
    longint t0, last_t0 = 0;
    int last_len = 0;
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx) begin
        t0 = cyc;
        n_start++;
        if (q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6 R7 unexpected start actual=1 expected=0");
          repeat (BITC * 10) @(negedge clk);
        end else begin
          it = q.pop_front();
          if (it.gap) check("R5 stop length / back-to-back", 64'(t0 - last_t0),
                            64'(last_len * DIV));
          repeat (BITC / 2) @(negedge clk);
          check("R2 start bit", tx, 0);
          for (int i = 0; i < it.wl; i++) begin
            repeat (BITC) @(negedge clk);
            check("R2 R3 data bit", tx, it.d[i]);
          end
          if (it.pm[0]) begin
            repeat (BITC) @(negedge clk);
            check("R4 parity bit", tx, exp_par(it));
          end
          repeat (BITC) @(negedge clk);
          check("R5 stop level", tx, 1);
          last_t0  = t0;
          last_len = frame_ticks(it);
        end
        n_done++;
      end
      prev = tx;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int base;
    logic [2:0] pms[5] = '{3'b000, 3'b001, 3'b011, 3'b101, 3'b111};
    repeat (3) @(negedge clk);
    check("R1 tx idle", tx, 1);
    check("R1 thr_empty", thr_empty, 1);
    check("R1 tx_empty", tx_empty, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // single 8N1 character and flag timing
    set_fmt(8, 3'b000, 0);
    send(8'hA5, 0);
    check("R9 thr_empty after write", thr_empty, 0);
    wait_start(1);
    check("R9 thr_empty while sending", thr_empty, 1);
    check("R9 tx_empty while sending", tx_empty, 0);
    wait_done(1);
    check("R9 tx_empty mid stop", tx_empty, 0);
    repeat (BITC) @(negedge clk);
    check("R9 tx_empty after stop", tx_empty, 1);

    // every word length with every parity mode
    for (int w = 5; w <= 8; w++) begin
      for (int p = 0; p < 5; p++) begin
        set_fmt(w, pms[p], 1'(p & 1));
        base = n_done;
        send(8'(8'h5B + w * 37 + p * 19), 0);
        wait_done(base + 1);
        repeat (BITC) @(negedge clk);
      end
    end

    // back-to-back pairs for stop lengths, released by CTS
    flow_auto = 1; cts_sel = 1;
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: set_fmt(5, 3'b000, 1);
        1: set_fmt(8, 3'b000, 1);
        2: set_fmt(7, 3'b000, 0);
        default: set_fmt(6, 3'b011, 1);
      endcase
      cts_n = 1;
      base = n_done;
      send(8'h3C ^ 8'(k), 0);
      send(8'hC3 ^ 8'(k), 1);
      repeat (BITC * 3) @(negedge clk);
      check("R7 no start while CTS busy", tx, 1);
      cts_n = 0;
      wait_done(base + 2);
      repeat (BITC * 2) @(negedge clk);
    end

    // CTS goes busy during a character: it completes, next waits
    set_fmt(8, 3'b001, 0);
    base = n_done;
    send(8'h81, 0);
    send(8'h7E, 1);
    wait_start(base + 1);
    cts_n = 1;
    wait_done(base + 1);
    repeat (BITC * 4) @(negedge clk);
    check("R7 gated after completed character", 64'(n_start), 64'(base + 1));
    check("R7 byte held in buffer", thr_empty, 0);
    q[0].gap = 0;
    cts_n = 0;
    wait_done(base + 2);
    repeat (BITC * 2) @(negedge clk);

    // gating disabled when only one enable set
    for (int k = 0; k < 2; k++) begin
      flow_auto = (k == 0); cts_sel = (k == 1);
      cts_n = 1;
      base = n_done;
      send(8'h96 + 8'(k), 0);
      repeat (BITC * 2) @(negedge clk);
      check("R8 CTS ignored", 64'(n_start), 64'(base + 1));
      wait_done(base + 1);
      repeat (BITC * 2) @(negedge clk);
    end
    cts_n = 0; flow_auto = 1; cts_sel = 1;

    // format captured at start
    set_fmt(8, 3'b011, 1);
    base = n_done;
    send(8'hE7, 0);
    wait_start(base + 1);
    repeat (BITC * 2) @(negedge clk);
    lcr = 6'b000000;
    wait_done(base + 1);
    repeat (BITC * 2) @(negedge clk);
    check("R10 format held to end", tx_empty, 1);

    // buffer depth: 65 writes while gated, only 64 sent in order
    set_fmt(8, 3'b000, 0);
    cts_n = 1;
    base = n_done;
    for (int i = 0; i < 64; i++) send(8'(i * 7 + 1), i != 0);
    write_byte(8'hFF);
    cts_n = 0;
    wait_done(base + 64);
    repeat (BITC * 20) @(negedge clk);
    check("R6 character count", 64'(n_start), 64'(base + 64));
    check("R6 scoreboard drained", 64'(q.size()), 0);
    check("R9 all empty", tx_empty, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule